// File: doc/BRIEF.md
# Owner-ID Hardware Lock Bank

This block is a bank of hardware lock registers that several processor cores share through one memory-mapped register port. Each lock holds the 8-bit identifier of the core that owns it, and the value zero marks the lock as free. Core identifiers are never zero.

A core claims a lock by writing its own identifier to the lock's word. It frees the lock by writing the same identifier a second time. Because the same write both takes and gives back a lock, software cannot rely on the write alone. After writing, a core reads the word back: if the read returns its own identifier, it holds the lock. Writes from a core that does not own a lock leave that lock untouched, so a failed claim has no effect.

The port handles one access per cycle. When several masters are arbitrated onto the port, their writes take effect in bus order, and each write is judged against the value left by the write before it. The number of locks is a parameter.

Top module: `owner_lock_bank`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clock edge) clears every lock to 0x00, which means free.
- R2: A write of a nonzero identifier to a free lock stores that identifier as the owner.
- R3: A write of an identifier equal to the lock's current nonzero owner clears the lock to 0x00.
- R4: A write of a nonzero identifier that differs from the lock's current nonzero owner leaves the lock unchanged.
- R5: A write whose low data byte is 0x00 leaves the lock unchanged.
- R6: Lock n sits at byte address 4*n. The lock index is taken from address bits [ADDR_W-1:2], and bits [1:0] are ignored. A read returns the owner in bits [7:0], with bits [31:8] at zero. Read data is combinational from the address.
- R7: An address whose lock index is NUM_LOCKS or greater reads as zero, and a write to it changes no lock.
- R8: Only bits [7:0] of the write data form the identifier. Bits [31:8] have no effect.
- R9: A write changes only the addressed lock. Every other lock keeps its value.
- R10: Writes on consecutive cycles to the same lock apply in order. Each write is judged against the value the previous write left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the accessed lock word |
| bus_wr | input | 1 | Write enable for the current cycle |
| bus_wdata | input | 32 | Write data; the low byte is the requester identifier |
| bus_rdata | output | 32 | Owner of the addressed lock, zero-extended |

## Verification
The tests first claim a free lock. They then try the following writes on a held lock: a write from a different core, a write of zero, and a release by the owner. Telling these apart shows that the design compares the identifier with the current owner, and does not simply store or toggle it.

Some writes put noise in the upper data bits, and others use unaligned addresses. These show that only the low byte and the word index are decoded.

A write to an index just past the last lock, made while lock 0 is free, would land on lock 0 if the decoder folded indices. Reading lock 0 afterwards catches that.

Same-cycle-order pairs are also tried: a claim followed at once by a release, and a claim followed at once by a foreign write. These show that each write sees the value the previous write left.

// File: rtl/spinlock_pkg.sv
// Package: shared widths and types for the owner-ID lock bank.
// Assumes an 8-bit identifier and a 32-bit register bus.
package spinlock_pkg;
    localparam int ID_W  = 8;
    localparam int BUS_W = 32;
    typedef logic [ID_W-1:0] owner_t;
    localparam owner_t FREE_ID = '0;
endpackage

// File: rtl/lock_decode.sv
// Module: lock_decode
// Turns a byte address into a word index, an in-range flag and a one-hot
// write-enable vector. Assumes NUM_LOCKS <= 2**(ADDR_W-2).
module lock_decode #(
    parameter int ADDR_W    = 8,
    parameter int NUM_LOCKS = 8,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    output logic [IDX_W-1:0]     word_idx,
    output logic                 idx_valid,
    output logic [NUM_LOCKS-1:0] we_vec
);
    logic unused_lo;

    // Purpose: split the address into the word index and the ignored byte lane.
    always_comb begin
        word_idx  = bus_addr[ADDR_W-1:2];
        unused_lo = ^bus_addr[1:0];
        idx_valid = (int'(word_idx) < NUM_LOCKS);
    end

    // Purpose: give each lock its own write strobe.
    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_we
        assign we_vec[g] = bus_wr && idx_valid && (word_idx == IDX_W'(g));
    end

    // Purpose: check that an out-of-range index strobes no lock.
    always_comb begin
        AST_OOR_NO_STROBE: assert (idx_valid || we_vec == '0); // R7
        AST_ONE_STROBE: assert ($onehot0(we_vec));             // R9
    end
endmodule

// File: rtl/lock_cell.sv
// Module: lock_cell
// Holds one lock register. A nonzero identifier claims a free lock. The
// owner's identifier frees it. Any other write is ignored.
// Assumes the write strobe is already qualified by address decode.
module lock_cell
    import spinlock_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   we,
    input  owner_t req_id,
    output owner_t owner
);
    // Purpose: owner register, updated by the claim/release rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= FREE_ID;
        end else if (we && req_id != FREE_ID) begin
            if (owner == FREE_ID)
                owner <= req_id;
            else if (owner == req_id)
                owner <= FREE_ID;
        end
    end

    AST_RESET_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> owner == FREE_ID); // R1
    AST_CLAIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && req_id != FREE_ID && owner == FREE_ID) |=> owner == $past(req_id)); // R2
    AST_OWNER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && owner != FREE_ID && req_id == owner) |=> owner == FREE_ID); // R3
    AST_FOREIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && req_id != FREE_ID && owner != FREE_ID && req_id != owner) |=> $stable(owner)); // R4
    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && req_id == FREE_ID) |=> $stable(owner)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(owner)); // R9
endmodule

// File: rtl/lock_rd_mux.sv
// Module: lock_rd_mux
// Selects the addressed owner onto the read bus, zero-extended. Returns zero
// for an out-of-range index. Assumes owners are packed lowest lock first.
module lock_rd_mux
    import spinlock_pkg::*;
#(
    parameter int NUM_LOCKS = 8,
    parameter int IDX_W     = 6
) (
    input  owner_t [NUM_LOCKS-1:0] owners,
    input  logic   [IDX_W-1:0]     word_idx,
    input  logic                   idx_valid,
    output logic   [BUS_W-1:0]     rdata
);
    // Purpose: combinational owner select.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_LOCKS; i++) begin
            if (idx_valid && word_idx == IDX_W'(i))
                rdata[ID_W-1:0] = owners[i];
        end
    end
endmodule

// File: rtl/owner_lock_bank.sv
// Module: owner_lock_bank
// Top of the lock bank: address decode, one lock_cell per lock, and the read
// mux. Assumes a single-cycle bus where each write lands at the rising edge.
module owner_lock_bank
    import spinlock_pkg::*;
#(
    parameter int NUM_LOCKS = 8,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic [IDX_W-1:0]       word_idx;
    logic                   idx_valid;
    logic [NUM_LOCKS-1:0]   we_vec;
    owner_t [NUM_LOCKS-1:0] owners;
    owner_t                 req_id;
    logic                   unused_hi;

    // Purpose: take the identifier from the low data byte only.
    always_comb begin
        req_id    = bus_wdata[ID_W-1:0];
        unused_hi = ^bus_wdata[BUS_W-1:ID_W];
    end

    lock_decode #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .word_idx  (word_idx),
        .idx_valid (idx_valid),
        .we_vec    (we_vec)
    );

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
        lock_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (we_vec[g]),
            .req_id (req_id),
            .owner  (owners[g])
        );
    end

    lock_rd_mux #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_rd (
        .owners    (owners),
        .word_idx  (word_idx),
        .idx_valid (idx_valid),
        .rdata     (bus_rdata)
    );

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_valid |-> bus_rdata == '0); // R7
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:ID_W] == '0); // R6
endmodule

// File: tb/owner_lock_bank_test.sv
`timescale 1ns/1ps
module owner_lock_bank_test;
    localparam int NL = 8;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    owner_lock_bank #(.NUM_LOCKS(NL), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Vector fields: {write, address, write data, expected owner after}
    localparam int NV = 12;
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 8'h00, 32'h0000_0011, 8'h11},  // R2 claim lock 0
        {1'b1, 8'h00, 32'h0000_0022, 8'h11},  // R4 foreign write
        {1'b1, 8'h00, 32'h0000_0000, 8'h11},  // R5 zero write
        {1'b1, 8'h00, 32'h0000_0011, 8'h00},  // R3 owner release
        {1'b1, 8'h04, 32'h0000_0022, 8'h22},  // R2 claim lock 1
        {1'b1, 8'h00, 32'h0000_0033, 8'h33},  // R2 claim lock 0 again
        {1'b0, 8'h04, 32'h0000_0000, 8'h22},  // R9 lock 1 kept
        {1'b1, 8'h06, 32'h0000_0022, 8'h00},  // R6 unaligned release of lock 1
        {1'b1, 8'h1C, 32'hABCD_EF05, 8'h05},  // R8 upper bits ignored on claim
        {1'b1, 8'h1C, 32'h0000_0105, 8'h00},  // R8 upper bits ignored on release
        {1'b1, 8'h20, 32'h0000_0044, 8'h00},  // R7 out-of-range index
        {1'b0, 8'h00, 32'h0000_0000, 8'h33}   // R9 lock 0 kept
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, {24'h0, exp});
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all locks free after reset
        for (int i = 0; i < NL; i++) read_check("R1", AW'(4 * i), 8'h00);

        // table walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][48]) begin
                do_write(VEC[v][47:40], VEC[v][39:8]);
            end else begin
                @(negedge clk);
            end
            read_check($sformatf("vector %0d", v), VEC[v][47:40], VEC[v][7:0]);
        end

        // R6/R7: far out-of-range address reads zero
        read_check("R7", 8'hFC, 8'h00);

        // R7: out-of-range write while lock 0 free must not alias onto lock 0
        do_write(8'h00, 32'h33);
        read_check("R3", 8'h00, 8'h00);
        do_write(8'h20, 32'h44);
        read_check("R7", 8'h00, 8'h00);

        // R10: claim then release on consecutive cycles
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 32'h55; bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = 32'h55;
        @(negedge clk);
        bus_wr = 1'b0;
        read_check("R10", 8'h08, 8'h00);

        // R10: claim then foreign write on consecutive cycles
        bus_addr = 8'h08; bus_wdata = 32'h55; bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = 32'h66;
        @(negedge clk);
        bus_wr = 1'b0;
        read_check("R10", 8'h08, 8'h55);

        // R1: reset in mid-run frees held locks
        do_write(8'h0C, 32'h77);
        read_check("R2", 8'h0C, 8'h77);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NL; i++) read_check("R1", AW'(4 * i), 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule